// File: doc/BRIEF.md
# Time-Slotted Shared Word Memory Arbiter

This block shares one single-port data memory of 128 words by 32 bits among three agents: a filter engine, a monitor port and a byte-wide processor bus. Access is not arbitrated on demand. A free-running slot sequencer hands each agent one clock slot in a fixed rotation: filter, then monitor, then processor. Exactly one agent can reach the memory in any cycle, so no contention logic is needed. An agent that has nothing to do in its slot leaves that cycle unused.

The two engine agents each use a 32-bit request/grant port. The grant appears in the agent's slot while its request is held. Read data comes back on the cycle after the grant, marked by a read-valid strobe. The memory is expected to return read data one clock after it is addressed.

The processor bus moves single bytes. A bridge holds byte-wide registers to build up words for writes and keeps a latched word for reads. It drives ready low while the processor waits for its slot. A typical use is for the engines to place converter results in the low words, for example 0x00 to 0x07: phase currents, phase A voltage, temperature and battery voltage, with spare words between them. Firmware then reads those words through the byte bus. Bridge states: BR_IDLE (ready high, accepts a strobe), BR_WAIT_WR (a full-word write waits for the processor slot), BR_WAIT_RD (a word fetch waits for the processor slot) and BR_CAPTURE (the fetched word is latched). Transitions: BR_IDLE to BR_WAIT_WR on a lane-3 write strobe, and BR_IDLE to BR_WAIT_RD on a lane-0 read strobe. BR_WAIT_WR returns to BR_IDLE in the processor slot. BR_WAIT_RD moves to BR_CAPTURE in the processor slot. BR_CAPTURE always returns to BR_IDLE. The sequencer has three states, SLOT_FILT, SLOT_MON and SLOT_CPU, and advances one step per clock in that order.

Top module: `smem_slot_arbiter`

## Requirements
- R1: After reset the slot sequence starts with the filter slot and advances one slot per clock in the order filter, monitor, processor, then repeats. A held filter request is granted every third cycle, and a held monitor request is granted in the cycle after each filter grant.
- R2: An engine agent is granted only in its own slot and only while it requests. When the owner of a slot has no request, mem_en stays low in that cycle.
- R3: At most one agent drives the memory port in any cycle.
- R4: An engine read granted in one cycle has its rvalid high in the next cycle, and its rdata then carries the addressed word. A granted write stores wdata at addr.
- R5: A processor write to byte lanes 0 to 2 (cpu_addr[1:0] = 0, 1, 2) loads that byte into a holding register without a memory access. cpu_ready stays high.
- R6: A processor write to lane 3 writes the word {lane3, lane2, lane1, lane0} to word cpu_addr[8:2] in the processor slot, with lane n at bits [8n+7:8n]. cpu_ready is low from the cycle after the strobe until the slot has been used.
- R7: A processor read of lane 0 fetches word cpu_addr[8:2] in the processor slot and latches all 32 bits. cpu_rdata then shows bits [7:0], and cpu_ready is low until the word is latched.
- R8: A processor read of lanes 1 to 3 returns bits [8n+7:8n] of the latched word without a memory access, so later memory changes are not seen. cpu_ready stays high.
- R9: A strobe raised while cpu_ready is low is ignored. It changes neither the memory nor the holding registers.
- R10: cpu_ready stays low for 1 to 3 cycles for a lane-3 write and for 2 to 4 cycles for a lane-0 read.
- R11: After reset cpu_ready is high, no memory access happens without a request, and the write and read holding registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fil_req | input | 1 | Filter engine access request |
| fil_we | input | 1 | Filter engine write (1) or read (0) |
| fil_addr | input | 7 | Filter engine word address |
| fil_wdata | input | 32 | Filter engine write word |
| fil_gnt | output | 1 | Filter engine access taken this cycle |
| fil_rvalid | output | 1 | Filter engine read word valid |
| fil_rdata | output | 32 | Filter engine read word |
| mon_req | input | 1 | Monitor access request |
| mon_we | input | 1 | Monitor write (1) or read (0) |
| mon_addr | input | 7 | Monitor word address |
| mon_wdata | input | 32 | Monitor write word |
| mon_gnt | output | 1 | Monitor access taken this cycle |
| mon_rvalid | output | 1 | Monitor read word valid |
| mon_rdata | output | 32 | Monitor read word |
| cpu_strobe | input | 1 | Processor access strobe, one cycle |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | 9 | Processor byte address: word in [8:2], lane in [1:0] |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Processor read byte |
| cpu_ready | output | 1 | Processor bus ready; low inserts wait states |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 7 | Memory word address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid one clock after access |

## Verification
The bench builds the block with its default parameters: 7 address bits, 32-bit words and 8-bit bytes. These give four byte lanes and a 128-word space, so every word address and lane can be reached. It places processor strobes at random phases of the three-slot rotation, which covers every wait-state count from the shortest to the longest. It also sends engine traffic that overwrites a word the processor has latched. The directed cases cover the start of the rotation after reset, idle slots, and strobes raised during wait states.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [1:0] {
        SLOT_FILT = 2'd0,
        SLOT_MON  = 2'd1,
        SLOT_CPU  = 2'd2
    } slot_e;

    typedef enum logic [1:0] {
        BR_IDLE    = 2'd0,
        BR_WAIT_WR = 2'd1,
        BR_WAIT_RD = 2'd2,
        BR_CAPTURE = 2'd3
    } br_state_e;

endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer
    import smem_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot
);

    slot_e slot_q;
    slot_e slot_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_FILT;
        end else begin
            slot_q <= slot_d;
        end
    end

    always_comb begin
        slot_d = SLOT_FILT;
        unique case (slot_q)
            SLOT_FILT: slot_d = SLOT_MON;
            SLOT_MON:  slot_d = SLOT_CPU;
            SLOT_CPU:  slot_d = SLOT_FILT;
            default:   slot_d = SLOT_FILT;
        endcase
    end

    assign slot = slot_q;

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_CPU) |=> (slot_q == SLOT_FILT)); // R1
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_FILT) |=> (slot_q == SLOT_MON)); // R1

endmodule

// File: rtl/engine_port.sv
module engine_port
    import smem_pkg::*;
#(
    parameter int    ADDR_W   = 7,
    parameter int    DATA_W   = 32,
    parameter slot_e OWN_SLOT = SLOT_FILT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             slot,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              gnt,
    output logic              rvalid,
    output logic              m_en,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata
);

    logic in_slot;
    logic rvalid_q;

    assign in_slot = (slot == OWN_SLOT);

    always_comb begin
        gnt     = in_slot && req;
        m_en    = gnt;
        m_we    = gnt && we;
        m_addr  = gnt ? addr  : '0;
        m_wdata = (gnt && we) ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= gnt && !we;
        end
    end

    assign rvalid = rvalid_q;

    AST_GNT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |=> !gnt); // R1

endmodule

// File: rtl/cpu_bridge.sv
module cpu_bridge
    import smem_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES   = DATA_W / BYTE_W,
    localparam int LANE_W  = $clog2(LANES),
    localparam int BADDR_W = ADDR_W + LANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  slot_e              slot,
    input  logic               strobe,
    input  logic               we,
    input  logic [BADDR_W-1:0] baddr,
    input  logic [BYTE_W-1:0]  wbyte,
    output logic [BYTE_W-1:0]  rbyte,
    output logic               ready,
    output logic               m_en,
    output logic               m_we,
    output logic [ADDR_W-1:0]  m_addr,
    output logic [DATA_W-1:0]  m_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    br_state_e state_q;
    br_state_e state_d;

    logic [LANE_W-1:0]        lane;
    logic [ADDR_W-1:0]        word;
    logic                     accept;
    logic                     my_slot;
    logic [ADDR_W-1:0]        pend_addr;
    logic [BYTE_W-1:0]        pend_top;
    logic [BYTE_W-1:0]        wr_hold [LANES-1];
    logic [DATA_W-BYTE_W-1:0] low_word;
    logic [DATA_W-1:0]        rd_hold;
    logic [BYTE_W-1:0]        rbyte_q;

    assign lane    = baddr[LANE_W-1:0];
    assign word    = baddr[BADDR_W-1:LANE_W];
    assign my_slot = (slot == SLOT_CPU);
    assign accept  = strobe && (state_q == BR_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BR_IDLE: begin
                if (accept && we && (lane == LAST_LANE)) begin
                    state_d = BR_WAIT_WR;
                end else if (accept && !we && (lane == '0)) begin
                    state_d = BR_WAIT_RD;
                end
            end
            BR_WAIT_WR: if (my_slot) state_d = BR_IDLE;
            BR_WAIT_RD: if (my_slot) state_d = BR_CAPTURE;
            BR_CAPTURE: state_d = BR_IDLE;
            default:    state_d = BR_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready   = 1'b0;
        m_en    = 1'b0;
        m_we    = 1'b0;
        unique case (state_q)
            BR_IDLE:    ready = 1'b1;
            BR_WAIT_WR: begin
                m_en = my_slot;
                m_we = my_slot;
            end
            BR_WAIT_RD: m_en = my_slot;
            BR_CAPTURE: ready = 1'b0;
            default:    ready = 1'b0;
        endcase
        m_addr  = m_en ? pend_addr : '0;
        m_wdata = m_we ? {pend_top, low_word} : '0;
    end

    // Write holding registers, one per lower lane
    for (genvar g = 0; g < LANES - 1; g++) begin : g_wr_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wr_hold[g] <= '0;
            end else if (accept && we && (lane == LANE_W'(g))) begin
                wr_hold[g] <= wbyte;
            end
        end
        assign low_word[g*BYTE_W +: BYTE_W] = wr_hold[g];
    end

    // Pending access, read holding register and returned byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_top  <= '0;
            rd_hold   <= '0;
            rbyte_q   <= '0;
        end else begin
            if (accept) begin
                pend_addr <= word;
                if (we && (lane == LAST_LANE)) begin
                    pend_top <= wbyte;
                end
                if (!we && (lane != '0)) begin
                    rbyte_q <= rd_hold[lane*BYTE_W +: BYTE_W];
                end
            end
            if (state_q == BR_CAPTURE) begin
                rd_hold <= mem_rdata;
                rbyte_q <= mem_rdata[BYTE_W-1:0];
            end
        end
    end

    assign rbyte = rbyte_q;

    // Wait-state window counter for checking
    logic [2:0] wait_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (ready) begin
            wait_cnt <= '0;
        end else if (wait_cnt != 3'd7) begin
            wait_cnt <= wait_cnt + 3'd1;
        end
    end

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (wait_cnt <= 3'd3)); // R10
    AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !m_en); // R5
    AST_WRITE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_en && m_we) |=> ready); // R6
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && strobe) |=> $stable(pend_addr)); // R9

endmodule

// File: rtl/smem_slot_arbiter.sv
module smem_slot_arbiter
    import smem_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int CPU_AW = ADDR_W + $clog2(DATA_W / BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fil_req,
    input  logic              fil_we,
    input  logic [ADDR_W-1:0] fil_addr,
    input  logic [DATA_W-1:0] fil_wdata,
    output logic              fil_gnt,
    output logic              fil_rvalid,
    output logic [DATA_W-1:0] fil_rdata,
    input  logic              mon_req,
    input  logic              mon_we,
    input  logic [ADDR_W-1:0] mon_addr,
    input  logic [DATA_W-1:0] mon_wdata,
    output logic              mon_gnt,
    output logic              mon_rvalid,
    output logic [DATA_W-1:0] mon_rdata,
    input  logic              cpu_strobe,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    slot_e slot;

    logic              f_en, f_we, m_en_mon, m_we_mon, c_en, c_we;
    logic [ADDR_W-1:0] f_addr, m_addr_mon, c_addr;
    logic [DATA_W-1:0] f_wdata, m_wdata_mon, c_wdata;

    slot_sequencer u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    engine_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OWN_SLOT(SLOT_FILT)) u_fil (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot    (slot),
        .req     (fil_req),
        .we      (fil_we),
        .addr    (fil_addr),
        .wdata   (fil_wdata),
        .gnt     (fil_gnt),
        .rvalid  (fil_rvalid),
        .m_en    (f_en),
        .m_we    (f_we),
        .m_addr  (f_addr),
        .m_wdata (f_wdata)
    );

    engine_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OWN_SLOT(SLOT_MON)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot    (slot),
        .req     (mon_req),
        .we      (mon_we),
        .addr    (mon_addr),
        .wdata   (mon_wdata),
        .gnt     (mon_gnt),
        .rvalid  (mon_rvalid),
        .m_en    (m_en_mon),
        .m_we    (m_we_mon),
        .m_addr  (m_addr_mon),
        .m_wdata (m_wdata_mon)
    );

    cpu_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (slot),
        .strobe    (cpu_strobe),
        .we        (cpu_we),
        .baddr     (cpu_addr),
        .wbyte     (cpu_wdata),
        .rbyte     (cpu_rdata),
        .ready     (cpu_ready),
        .m_en      (c_en),
        .m_we      (c_we),
        .m_addr    (c_addr),
        .m_wdata   (c_wdata),
        .mem_rdata (mem_rdata)
    );

    // Memory port steered by the slot owner
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (slot)
            SLOT_FILT: begin
                mem_en = f_en; mem_we = f_we; mem_addr = f_addr; mem_wdata = f_wdata;
            end
            SLOT_MON: begin
                mem_en = m_en_mon; mem_we = m_we_mon; mem_addr = m_addr_mon; mem_wdata = m_wdata_mon;
            end
            SLOT_CPU: begin
                mem_en = c_en; mem_we = c_we; mem_addr = c_addr; mem_wdata = c_wdata;
            end
            default: mem_en = 1'b0;
        endcase
    end

    assign fil_rdata = mem_rdata;
    assign mon_rdata = mem_rdata;

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({f_en, m_en_mon, c_en})); // R3
    AST_MON_AFTER_FIL: assert property (@(posedge clk) disable iff (!rst_n)
        (fil_gnt && mon_req) |=> mon_gnt); // R1
    AST_RVALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (fil_rvalid || mon_rvalid) |-> $past(mem_en && !mem_we)); // R4
    AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!fil_req && !mon_req && cpu_ready) |-> !mem_en); // R2

endmodule

// File: tb/tb_smem_slot_arbiter.sv
module tb_smem_slot_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fil_req = 0, fil_we = 0, mon_req = 0, mon_we = 0;
    logic [6:0]  fil_addr = '0, mon_addr = '0;
    logic [31:0] fil_wdata = '0, mon_wdata = '0;
    logic        fil_gnt, fil_rvalid, mon_gnt, mon_rvalid;
    logic [31:0] fil_rdata, mon_rdata;
    logic        cpu_strobe = 0, cpu_we = 0;
    logic [8:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic        mem_en, mem_we;
    logic [6:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    logic [31:0] mem_arr [128];
    logic [31:0] shadow  [128];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    smem_slot_arbiter dut (
        .clk(clk), .rst_n(rst_n),
        .fil_req(fil_req), .fil_we(fil_we), .fil_addr(fil_addr), .fil_wdata(fil_wdata),
        .fil_gnt(fil_gnt), .fil_rvalid(fil_rvalid), .fil_rdata(fil_rdata),
        .mon_req(mon_req), .mon_we(mon_we), .mon_addr(mon_addr), .mon_wdata(mon_wdata),
        .mon_gnt(mon_gnt), .mon_rvalid(mon_rvalid), .mon_rdata(mon_rdata),
        .cpu_strobe(cpu_strobe), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Memory model: one-clock read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_arr[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem_arr[mem_addr];
        end
    end

    function automatic logic [7:0] lane_of(input logic [31:0] w, input int n);
        return w[n*8 +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic cpu_wr(input logic [6:0] w, input int ln, input logic [7:0] b, output int waits);
        @(negedge clk);
        cpu_strobe = 1; cpu_we = 1; cpu_addr = {w, 2'(ln)}; cpu_wdata = b;
        @(negedge clk);
        cpu_strobe = 0;
        waits = 0;
        while (!cpu_ready) begin waits++; @(negedge clk); end
    endtask

    task automatic cpu_rd(input logic [6:0] w, input int ln, output logic [7:0] b, output int waits);
        @(negedge clk);
        cpu_strobe = 1; cpu_we = 0; cpu_addr = {w, 2'(ln)};
        @(negedge clk);
        cpu_strobe = 0;
        waits = 0;
        while (!cpu_ready) begin waits++; @(negedge clk); end
        b = cpu_rdata;
    endtask

    task automatic cpu_word_wr(input logic [6:0] w, input logic [31:0] d);
        int wt;
        for (int n = 0; n < 3; n++) begin
            cpu_wr(w, n, lane_of(d, n), wt);
            chk(wt == 0, "R5 low-lane write ready", 32'(wt), 0);
        end
        cpu_wr(w, 3, lane_of(d, 3), wt);
        chk(wt >= 1 && wt <= 3, "R10 write wait count", 32'(wt), 3);
        shadow[w] = d;
    endtask

    task automatic cpu_word_rd(input logic [6:0] w, output logic [31:0] d);
        int wt;
        logic [7:0] b;
        cpu_rd(w, 0, b, wt);
        chk(wt >= 2 && wt <= 4, "R10 read wait count", 32'(wt), 4);
        d[7:0] = b;
        for (int n = 1; n < 4; n++) begin
            cpu_rd(w, n, b, wt);
            chk(wt == 0, "R8 upper-lane read ready", 32'(wt), 0);
            d[n*8 +: 8] = b;
        end
    endtask

    task automatic eng(input bit mon, input bit we, input logic [6:0] a, input logic [31:0] d,
                       output logic [31:0] rd);
        @(negedge clk);
        if (mon) begin mon_req = 1; mon_we = we; mon_addr = a; mon_wdata = d; end
        else     begin fil_req = 1; fil_we = we; fil_addr = a; fil_wdata = d; end
        forever begin
            #1;
            if (mon ? mon_gnt : fil_gnt) break;
            @(negedge clk);
        end
        @(negedge clk);
        fil_req = 0; mon_req = 0;
        rd = 'x;
        if (!we) begin
            chk(mon ? mon_rvalid : fil_rvalid, "R4 rvalid after grant", 0, 1);
            rd = mon ? mon_rdata : fil_rdata;
        end
        if (we) shadow[a] = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
        end
    end

    initial begin
        logic [31:0] rw, dummy, exp;
        logic [7:0]  b;
        int wt;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 128; i++) begin mem_arr[i] = '0; shadow[i] = '0; end

        repeat (3) @(negedge clk);
        chk(cpu_ready === 1'b1, "R11 ready in reset", 32'(cpu_ready), 1);
        chk(mem_en === 1'b0, "R11 no access in reset", 32'(mem_en), 0);

        // R1/R2: rotation from reset release with both engines requesting reads
        @(negedge clk);
        rst_n = 1; fil_req = 1; mon_req = 1; fil_addr = 7'd1; mon_addr = 7'd2;
        for (int i = 0; i < 12; i++) begin
            #1;
            chk(fil_gnt === (i % 3 == 0), "R1 filter slot", 32'(fil_gnt), 32'(i % 3 == 0));
            chk(mon_gnt === (i % 3 == 1), "R1 monitor slot", 32'(mon_gnt), 32'(i % 3 == 1));
            if (i % 3 == 2) chk(mem_en === 1'b0, "R2 idle processor slot", 32'(mem_en), 0);
            @(negedge clk);
        end
        fil_req = 0;
        for (int i = 0; i < 6; i++) begin
            #1;
            chk(!(mem_en && !mon_gnt), "R2 idle filter slot", 32'(mem_en), 32'(mon_gnt));
            chk(!(fil_gnt && mon_gnt), "R3 single owner", 32'({fil_gnt, mon_gnt}), 0);
            @(negedge clk);
        end
        mon_req = 0;

        // R11: read holding register is zero after reset
        cpu_rd(7'd0, 1, b, wt);
        chk(b == 8'h00, "R11 read hold zero", 32'(b), 0);

        // R4: converter-result words written by the filter, read by the processor
        for (int a = 0; a < 8; a++) eng(0, 1, 7'(a), 32'hA0B0C000 + 32'(a), dummy);
        for (int a = 0; a < 8; a++) begin
            cpu_word_rd(7'(a), rw);
            chk(rw == shadow[a], "R7 R8 result word read", rw, shadow[a]);
        end

        // R6: processor word write observed by the monitor
        cpu_word_wr(7'd20, 32'h44332211);
        eng(1, 0, 7'd20, 0, rw);
        chk(rw == 32'h44332211, "R6 assembled word", rw, 32'h44332211);

        // R8: latched copy is not refreshed by a later memory write
        cpu_word_rd(7'd20, rw);
        eng(0, 1, 7'd20, 32'hDEADBEEF, dummy);
        cpu_rd(7'd20, 2, b, wt);
        chk(b == 8'h33, "R8 latched copy kept", 32'(b), 32'h33);
        cpu_rd(7'd20, 0, b, wt);
        chk(b == 8'hEF, "R7 fresh fetch", 32'(b), 32'hEF);

        // R9: strobe during wait states is ignored
        cpu_wr(7'd30, 0, 8'h01, wt);
        cpu_wr(7'd30, 1, 8'h02, wt);
        cpu_wr(7'd30, 2, 8'h03, wt);
        @(negedge clk);
        cpu_strobe = 1; cpu_we = 1; cpu_addr = {7'd30, 2'd3}; cpu_wdata = 8'h04;
        @(negedge clk);
        cpu_addr = {7'd31, 2'd0}; cpu_wdata = 8'hEE;
        @(negedge clk);
        cpu_strobe = 0;
        while (!cpu_ready) @(negedge clk);
        shadow[30] = 32'h04030201;
        cpu_wr(7'd32, 3, 8'h55, wt);
        shadow[32] = 32'h55030201;
        eng(0, 0, 7'd30, 0, rw);
        chk(rw == 32'h04030201, "R9 busy strobe word", rw, 32'h04030201);
        eng(0, 0, 7'd32, 0, rw);
        chk(rw == 32'h55030201, "R9 hold untouched", rw, 32'h55030201);
        eng(0, 0, 7'd31, 0, rw);
        chk(rw == 32'h0, "R9 no stray write", rw, 0);

        // R5: low-lane writes leave memory untouched
        cpu_wr(7'd40, 0, 8'h99, wt);
        eng(1, 0, 7'd40, 0, rw);
        chk(rw == shadow[40], "R5 no memory write", rw, shadow[40]);

        // Random mix, random phase offsets
        for (int it = 0; it < 40; it++) begin
            logic [6:0] a;
            a = 7'($urandom_range(8, 127));
            repeat ($urandom_range(0, 2)) @(negedge clk);
            if ($urandom_range(0, 1) == 1) cpu_word_wr(a, $urandom());
            else eng($urandom_range(0, 1) == 1, 1, a, $urandom(), dummy);
            a = 7'($urandom_range(0, 127));
            exp = shadow[a];
            if ($urandom_range(0, 1) == 1) begin
                cpu_word_rd(a, rw);
                chk(rw == exp, "R7 R8 random readback", rw, exp);
            end else begin
                eng($urandom_range(0, 1) == 1, 0, a, 0, rw);
                chk(rw == exp, "R4 random engine read", rw, exp);
            end
        end

        done = 1;
        summary();
    end

endmodule